// File: doc/BRIEF.md
# Flash Operation Command Sequencer

This block sits between a software-visible command register and the word-level request port of a flash memory. Software writes a command made of an operation code (read, program or erase), an erase type, a partition select, a program type, a word count and a start byte address. When the start bit is written, the block rounds the address down to the granularity that the operation needs. It then presents one request per flash word to the memory port. When the last acknowledgement arrives, or when a request returns an error, it raises a single-cycle done pulse.

While a command is pending or running, the block drops its write-enable output. It then ignores every write to the command and address registers, including a new start bit. It also accepts an erase-suspend request. The block forwards that request to the flash port only while an erase is running and holds it there until the port acknowledges it. A suspend request that arrives at any other time is dropped.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `regwen_o` is 1 and `fl_req_o`, `done_o`, `err_o` and `fl_susp_req_o` are 0.
- R2: A command write with the start bit set drops `regwen_o` from the next cycle. The start bit may come in the same write as the other fields or in a later write. `regwen_o` returns to 1 in the cycle that `done_o` is high, whether the operation succeeded or failed.
- R3: While `regwen_o` is 0, writes to the command fields, the start bit and the address are ignored. No operation starts afterwards, and a later start uses the address that was held before.
- R4: Op code 0 (read) and op code 1 (program) issue count+1 requests. The first request is at the address rounded down to a multiple of 8. Each later request is at the previous address plus 8. `fl_req_o` and `fl_addr_o` hold steady until `fl_ack_i`.
- R5: Op code 2 (erase) issues exactly one request, whatever the count. With `cmd_bank_i` at 0 (page erase) the address is rounded down to a multiple of 2048. With `cmd_bank_i` at 1 (bank erase) it is rounded down to a multiple of 524288. `fl_op_o`, `fl_bank_o` and `fl_part_o` carry the command fields during the request. For a bank erase, `fl_part_o` at 1 asks for the info partition to be erased as well.
- R6: `done_o` is high for exactly one cycle, the cycle after the last request is acknowledged.
- R7: An acknowledgement with `fl_err_i` at 1 ends the operation. No further requests are issued, `done_o` pulses and `err_o` becomes 1. `err_o` stays at 1 until the next command is accepted without rejection.
- R8: A program whose type is disabled is rejected. The type comes from `cmd_repair_i`: bit 0 of `prog_type_en_i` enables normal programs and bit 1 enables repair programs. Op code 3 is rejected in the same way. A rejected command issues no request and gives `done_o` and `err_o` in the cycle after acceptance.
- R9: A suspend request (`susp_set_i`) made while no erase is running never reaches `fl_susp_req_o`, and no suspend stays pending.
- R10: A suspend request made during an erase raises `fl_susp_req_o` in the next cycle. The request holds until `fl_susp_ack_i` and is low in the cycle after the acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Write strobe for the command fields and start bit |
| cmd_op_i | input | 2 | Operation code: 0 read, 1 program, 2 erase |
| cmd_bank_i | input | 1 | Erase type: 0 page, 1 bank |
| cmd_part_i | input | 1 | Partition select; for bank erase, also erase the info partition |
| cmd_repair_i | input | 1 | Program type: 0 normal, 1 repair |
| cmd_cnt_i | input | CNT_W | Word count minus one |
| cmd_start_i | input | 1 | Start bit written with the command |
| addr_we_i | input | 1 | Write strobe for the start address |
| addr_i | input | ADDR_W | Start byte address |
| prog_type_en_i | input | 2 | Allowed program types (bit 0 normal, bit 1 repair) |
| susp_set_i | input | 1 | Erase-suspend request |
| regwen_o | output | 1 | Command and address registers writable |
| done_o | output | 1 | Operation finished pulse |
| err_o | output | 1 | Last operation failed or was rejected |
| fl_req_o | output | 1 | Flash word request |
| fl_op_o | output | 2 | Operation code of the request |
| fl_bank_o | output | 1 | Bank erase select of the request |
| fl_part_o | output | 1 | Partition select of the request |
| fl_addr_o | output | ADDR_W | Aligned byte address of the request |
| fl_ack_i | input | 1 | Request completed |
| fl_err_i | input | 1 | Completed request failed (valid with ack) |
| fl_susp_req_o | output | 1 | Erase-suspend request to the flash |
| fl_susp_ack_i | input | 1 | Flash acknowledges the suspend |

## Verification
The assertions assume that the flash port raises `fl_ack_i` only while `fl_req_o` is high, and that `fl_err_i` has meaning only alongside an acknowledgement. The bench responder keeps to this. It decides at each clock whether to acknowledge, using only the request it currently sees, after a programmable latency. It injects an error only on an acknowledge cycle. `fl_susp_ack_i` is driven only while a suspend is pending. The writes made while the registers are locked are issued only during running operations.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } fop_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_st_e;
endpackage

// File: rtl/fcs_cmd_regs.sv
module fcs_cmd_regs
  import flash_seq_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_open_i,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_bank_i,
  input  logic              cmd_part_i,
  input  logic              cmd_repair_i,
  input  logic [CNT_W-1:0]  cmd_cnt_i,
  input  logic              cmd_start_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              accept_i,
  output fop_e              op_o,
  output logic              bank_o,
  output logic              part_o,
  output logic              repair_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              start_o
);
  logic cmd_en, addr_en, start_en, start_d;

  always_comb begin
    cmd_en   = cmd_we_i & wr_open_i;
    addr_en  = addr_we_i & wr_open_i;
    start_en = cmd_en | accept_i;
    start_d  = cmd_en ? cmd_start_i : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o     <= OP_READ;
      bank_o   <= 1'b0;
      part_o   <= 1'b0;
      repair_o <= 1'b0;
      cnt_o    <= '0;
    end else if (cmd_en) begin
      op_o     <= fop_e'(cmd_op_i);
      bank_o   <= cmd_bank_i;
      part_o   <= cmd_part_i;
      repair_o <= cmd_repair_i;
      cnt_o    <= cmd_cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (addr_en) addr_o <= addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       start_o <= 1'b0;
    else if (start_en) start_o <= start_d;
  end
endmodule

// File: rtl/fcs_addr_align.sv
module fcs_addr_align
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WORD_BYTES = 8,
  parameter int PAGE_BYTES = 2048,
  parameter int BANK_BYTES = 524288
) (
  input  fop_e              op_i,
  input  logic              bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] aligned_o
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] BANK_MASK = ~ADDR_W'(BANK_BYTES - 1);

  always_comb begin
    if (op_i == OP_ERASE) begin
      aligned_o = addr_i & (bank_i ? BANK_MASK : PAGE_MASK);
    end else begin
      aligned_o = addr_i & WORD_MASK;
    end
  end
endmodule

// File: rtl/fcs_word_engine.sv
module fcs_word_engine
  import flash_seq_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 20,
  parameter int WORD_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  fop_e              op_i,
  input  logic              repair_i,
  input  logic [1:0]        prog_type_en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              fl_ack_i,
  input  logic              fl_err_i,
  output logic              idle_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seq_st_e           st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              done_d, err_q, err_d;
  logic              walk_en, err_en;
  logic              type_ok;

  always_comb begin
    type_ok  = (op_i == OP_PROG) ? prog_type_en_i[repair_i] : (op_i != OP_BAD);
    accept_o = start_i & (st_q == SEQ_IDLE);
    reject_o = accept_o & ~type_ok;

    st_d    = st_q;
    cur_d   = cur_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    err_d   = err_q;
    walk_en = 1'b0;
    err_en  = 1'b0;

    if (accept_o) begin
      err_en = 1'b1;
      if (!type_ok) begin
        done_d = 1'b1;
        err_d  = 1'b1;
      end else begin
        st_d    = SEQ_BUSY;
        err_d   = 1'b0;
        walk_en = 1'b1;
        cur_d   = base_i;
        rem_d   = (op_i == OP_ERASE) ? '0 : cnt_i;
      end
    end else if ((st_q == SEQ_BUSY) && fl_ack_i) begin
      if (fl_err_i) begin
        st_d   = SEQ_IDLE;
        done_d = 1'b1;
        err_d  = 1'b1;
        err_en = 1'b1;
      end else if (rem_q == '0) begin
        st_d   = SEQ_IDLE;
        done_d = 1'b1;
      end else begin
        walk_en = 1'b1;
        cur_d   = cur_q + STEP;
        rem_d   = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      rem_q <= '0;
    end else if (walk_en) begin
      cur_q <= cur_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign idle_o     = (st_q == SEQ_IDLE);
  assign busy_o     = (st_q == SEQ_BUSY);
  assign cur_addr_o = cur_q;
  assign err_o      = err_q;
endmodule

// File: rtl/fcs_susp_ctrl.sv
module fcs_susp_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic erase_busy_i,
  input  logic op_ack_i,
  input  logic susp_ack_i,
  output logic pend_o
);
  logic pend_d;

  always_comb begin
    pend_d = (pend_o | set_i) & erase_busy_i & ~op_ack_i & ~susp_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= pend_d;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ADDR_W     = 20,
  parameter int WORD_BYTES = 8,
  parameter int PAGE_BYTES = 2048,
  parameter int BANK_BYTES = 524288
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_bank_i,
  input  logic              cmd_part_i,
  input  logic              cmd_repair_i,
  input  logic [CNT_W-1:0]  cmd_cnt_i,
  input  logic              cmd_start_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        prog_type_en_i,
  input  logic              susp_set_i,
  output logic              regwen_o,
  output logic              done_o,
  output logic              err_o,
  output logic              fl_req_o,
  output logic [1:0]        fl_op_o,
  output logic              fl_bank_o,
  output logic              fl_part_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic              fl_ack_i,
  input  logic              fl_err_i,
  output logic              fl_susp_req_o,
  input  logic              fl_susp_ack_i
);
  fop_e              reg_op;
  logic              reg_bank, reg_part, reg_repair, reg_start;
  logic [CNT_W-1:0]  reg_cnt;
  logic [ADDR_W-1:0] reg_addr, base_addr;
  logic              eng_idle, eng_busy, accept_w, reject_w;

  assign regwen_o = eng_idle & ~reg_start;

  fcs_cmd_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_open_i    (regwen_o),
    .cmd_we_i     (cmd_we_i),
    .cmd_op_i     (cmd_op_i),
    .cmd_bank_i   (cmd_bank_i),
    .cmd_part_i   (cmd_part_i),
    .cmd_repair_i (cmd_repair_i),
    .cmd_cnt_i    (cmd_cnt_i),
    .cmd_start_i  (cmd_start_i),
    .addr_we_i    (addr_we_i),
    .addr_i       (addr_i),
    .accept_i     (accept_w),
    .op_o         (reg_op),
    .bank_o       (reg_bank),
    .part_o       (reg_part),
    .repair_o     (reg_repair),
    .cnt_o        (reg_cnt),
    .addr_o       (reg_addr),
    .start_o      (reg_start)
  );

  fcs_addr_align #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
    .PAGE_BYTES(PAGE_BYTES), .BANK_BYTES(BANK_BYTES)
  ) u_align (
    .op_i      (reg_op),
    .bank_i    (reg_bank),
    .addr_i    (reg_addr),
    .aligned_o (base_addr)
  );

  fcs_word_engine #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_eng (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (reg_start),
    .op_i           (reg_op),
    .repair_i       (reg_repair),
    .prog_type_en_i (prog_type_en_i),
    .cnt_i          (reg_cnt),
    .base_i         (base_addr),
    .fl_ack_i       (fl_ack_i),
    .fl_err_i       (fl_err_i),
    .idle_o         (eng_idle),
    .accept_o       (accept_w),
    .reject_o       (reject_w),
    .busy_o         (eng_busy),
    .cur_addr_o     (fl_addr_o),
    .done_o         (done_o),
    .err_o          (err_o)
  );

  fcs_susp_ctrl u_susp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (susp_set_i),
    .erase_busy_i (eng_busy & (reg_op == OP_ERASE)),
    .op_ack_i     (fl_ack_i),
    .susp_ack_i   (fl_susp_ack_i),
    .pend_o       (fl_susp_req_o)
  );

  assign fl_req_o  = eng_busy;
  assign fl_op_o   = reg_op;
  assign fl_bank_o = reg_bank;
  assign fl_part_o = reg_part;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W     = 20,
  parameter int WORD_BYTES = 8,
  parameter int PAGE_BYTES = 2048
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              regwen_o,
  input logic              done_o,
  input logic              err_o,
  input logic              fl_req_o,
  input logic [1:0]        fl_op_o,
  input logic              fl_bank_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic              fl_ack_i,
  input logic              fl_err_i,
  input logic              fl_susp_req_o,
  input logic              fl_susp_ack_i,
  input logic [ADDR_W-1:0] held_addr,
  input logic              accept_w,
  input logic              reject_w
);
  localparam logic [ADDR_W-1:0] WLOW = ADDR_W'(WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] PLOW = ADDR_W'(PAGE_BYTES - 1);

  AST_REQ_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> !regwen_o); // R2
  AST_DONE_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> regwen_o); // R2
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regwen_o |=> $stable(held_addr)); // R3
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_ack_i) |=> (fl_req_o && $stable(fl_addr_o))); // R4
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> ((fl_addr_o & WLOW) == '0)); // R4
  AST_ERASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_op_o == 2'd2) |-> ((fl_addr_o & PLOW) == '0)); // R5
  AST_ERASE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_ack_i && fl_op_o == 2'd2) |=> (!fl_req_o && done_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_ack_i && fl_err_i) |=> (!fl_req_o && done_o && err_o)); // R7
  AST_REJECT_NOREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && reject_w) |=> (!fl_req_o && done_o && err_o)); // R8
  AST_SUSP_ERASE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_susp_req_o |-> (fl_req_o && fl_op_o == 2'd2)); // R9
  AST_SUSP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_susp_req_o && fl_susp_ack_i) |=> !fl_susp_req_o); // R10
  AST_SUSP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_susp_req_o && !fl_susp_ack_i && !fl_ack_i) |=> fl_susp_req_o); // R10

  logic unused_ok;
  assign unused_ok = fl_bank_o;
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .regwen_o      (regwen_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .fl_req_o      (fl_req_o),
  .fl_op_o       (fl_op_o),
  .fl_bank_o     (fl_bank_o),
  .fl_addr_o     (fl_addr_o),
  .fl_ack_i      (fl_ack_i),
  .fl_err_i      (fl_err_i),
  .fl_susp_req_o (fl_susp_req_o),
  .fl_susp_ack_i (fl_susp_ack_i),
  .held_addr     (reg_addr),
  .accept_w      (accept_w),
  .reject_w      (reject_w)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int CNT_W = 12;
  localparam int AW = 20;

  logic clk, rst_n;
  logic cmd_we, cmd_bank, cmd_part, cmd_repair, cmd_start, addr_we, susp_set;
  logic [1:0] cmd_op, prog_en;
  logic [CNT_W-1:0] cmd_cnt;
  logic [AW-1:0] addr_in;
  logic regwen, done, err, fl_req, fl_bank, fl_part, fl_susp_req;
  logic [1:0] fl_op;
  logic [AW-1:0] fl_addr;
  logic fl_ack, fl_err, fl_susp_ack;

  int checks = 0, errors = 0;
  int ack_lat = 0, err_idx = -1, nreq = 0, wcnt = 0;
  int addrs[$];

  flash_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_op_i(cmd_op),
    .cmd_bank_i(cmd_bank), .cmd_part_i(cmd_part), .cmd_repair_i(cmd_repair),
    .cmd_cnt_i(cmd_cnt), .cmd_start_i(cmd_start), .addr_we_i(addr_we),
    .addr_i(addr_in), .prog_type_en_i(prog_en), .susp_set_i(susp_set),
    .regwen_o(regwen), .done_o(done), .err_o(err), .fl_req_o(fl_req),
    .fl_op_o(fl_op), .fl_bank_o(fl_bank), .fl_part_o(fl_part),
    .fl_addr_o(fl_addr), .fl_ack_i(fl_ack), .fl_err_i(fl_err),
    .fl_susp_req_o(fl_susp_req), .fl_susp_ack_i(fl_susp_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  int m_busy, m_start, m_op, m_bank, m_part, m_rep, m_cnt, m_addr;
  int m_cur, m_rem, m_done, m_err, m_susp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_start = 0; m_op = 0; m_bank = 0; m_part = 0; m_rep = 0;
      m_cnt = 0; m_addr = 0; m_cur = 0; m_rem = 0; m_done = 0; m_err = 0; m_susp = 0;
    end else begin
      int open, nsusp, ndone, nstart;
      open   = (m_busy == 0 && m_start == 0);
      nsusp  = ((m_susp != 0 || susp_set) && m_busy != 0 && m_op == 2
                && !fl_ack && !fl_susp_ack) ? 1 : 0;
      ndone  = 0;
      nstart = m_start;
      if (m_busy == 0 && m_start != 0) begin
        nstart = 0;
        if ((m_op == 1 && !prog_en[m_rep]) || m_op == 3) begin
          ndone = 1; m_err = 1;
        end else begin
          m_busy = 1; m_err = 0;
          if (m_op == 2) m_cur = m_bank ? (m_addr / 524288) * 524288 : (m_addr / 2048) * 2048;
          else           m_cur = (m_addr / 8) * 8;
          m_rem = (m_op == 2) ? 0 : m_cnt;
        end
      end else if (m_busy != 0 && fl_ack) begin
        if (fl_err) begin m_err = 1; ndone = 1; m_busy = 0; end
        else if (m_rem == 0) begin ndone = 1; m_busy = 0; end
        else begin m_cur = (m_cur + 8) % (1 << AW); m_rem--; end
      end
      if (cmd_we && open) begin
        m_op = cmd_op; m_bank = cmd_bank; m_part = cmd_part; m_rep = cmd_repair;
        m_cnt = cmd_cnt; nstart = cmd_start;
      end
      if (addr_we && open) m_addr = addr_in;
      m_start = nstart; m_done = ndone; m_susp = nsusp;
    end
  end

  // Clock-by-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(regwen == (m_busy == 0 && m_start == 0), "R2", "regwen", regwen, (m_busy == 0 && m_start == 0));
      chk(fl_req == (m_busy != 0), "R4", "fl_req", fl_req, m_busy);
      if (m_busy != 0) begin
        chk(fl_addr == AW'(m_cur), "R4", "fl_addr", fl_addr, m_cur);
        chk(fl_op == 2'(m_op) && fl_part == m_part[0], "R5", "fl_op/part", {fl_op, fl_part}, {m_op[1:0], m_part[0]});
      end
      chk(done == m_done[0], "R6", "done", done, m_done);
      chk(err == m_err[0], "R7", "err", err, m_err);
      chk(fl_susp_req == m_susp[0], "R10", "susp_req", fl_susp_req, m_susp);
    end
  end

  // Flash responder
  initial begin
    fl_ack = 0; fl_err = 0;
    forever begin
      @(posedge clk); #1;
      fl_ack = 0; fl_err = 0;
      if (rst_n && fl_req) begin
        if (wcnt >= ack_lat) begin
          fl_ack = 1; fl_err = (nreq == err_idx);
          addrs.push_back(int'(fl_addr)); nreq++; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic clr_log();
    nreq = 0; wcnt = 0; addrs.delete();
  endtask

  task automatic wcmd(input int op, input bit bank, input bit part, input bit rep,
                      input int cnt, input bit start);
    @(posedge clk); #2;
    cmd_we = 1; cmd_op = 2'(op); cmd_bank = bank; cmd_part = part;
    cmd_repair = rep; cmd_cnt = CNT_W'(cnt); cmd_start = start;
    @(posedge clk); #2;
    cmd_we = 0; cmd_start = 0;
  endtask

  task automatic waddr(input int a);
    @(posedge clk); #2; addr_we = 1; addr_in = AW'(a);
    @(posedge clk); #2; addr_we = 0;
  endtask

  task automatic pulse_susp();
    @(posedge clk); #2; susp_set = 1;
    @(posedge clk); #2; susp_set = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    @(negedge clk);
    while (!done && t < 3000) begin @(negedge clk); t++; end
  endtask

  initial begin
    rst_n = 0; cmd_we = 0; cmd_op = 0; cmd_bank = 0; cmd_part = 0; cmd_repair = 0;
    cmd_cnt = 0; cmd_start = 0; addr_we = 0; addr_in = 0; prog_en = 2'b11;
    susp_set = 0; fl_susp_ack = 0;
    repeat (3) @(posedge clk); #2; rst_n = 1;
    @(negedge clk);
    chk(regwen && !fl_req && !done && !err && !fl_susp_req, "R1", "reset state",
        {regwen, fl_req, done, err, fl_susp_req}, 5'b10000);

    // R4: read of 10 words from an unaligned address
    clr_log(); waddr('h00013); wcmd(0, 0, 0, 0, 9, 1); wait_done();
    chk(nreq == 10, "R4", "read count", nreq, 10);
    chk(addrs[0] == 'h10 && addrs[9] == 'h58, "R4", "read last addr", addrs[9], 'h58);

    // R2: start written after the fields, program with latency
    clr_log(); ack_lat = 2; waddr('h1FFF5);
    wcmd(1, 0, 0, 0, 2, 0);
    chk(regwen == 1, "R2", "open before start", regwen, 1);
    wcmd(1, 0, 0, 0, 2, 1); wait_done();
    chk(nreq == 3 && addrs[2] == 'h20000, "R4", "prog wrap addr", addrs[2], 'h20000);

    // R5: page erase ignores count
    clr_log(); ack_lat = 1; waddr('h12345); wcmd(2, 0, 0, 0, 5, 1); wait_done();
    chk(nreq == 1 && addrs[0] == 'h12000, "R5", "page erase", addrs[0], 'h12000);

    // R5: bank erase with info partition
    clr_log(); waddr('h9ABCD); wcmd(2, 1, 1, 0, 7, 1); wait_done();
    chk(nreq == 1 && addrs[0] == 'h80000, "R5", "bank erase", addrs[0], 'h80000);

    // R7: error on third word
    clr_log(); ack_lat = 0; err_idx = 2; waddr('h200); wcmd(0, 0, 0, 0, 7, 1); wait_done();
    @(negedge clk);
    chk(nreq == 3 && err == 1, "R7", "error stop", nreq, 3);
    err_idx = -1;
    clr_log(); wcmd(0, 0, 0, 0, 0, 1); wait_done();
    chk(err == 0, "R7", "err cleared", err, 0);

    // R8: repair program disabled, and reserved op code
    clr_log(); prog_en = 2'b01; wcmd(1, 0, 0, 1, 3, 1); wait_done();
    chk(nreq == 0 && err == 1, "R8", "repair rejected", nreq, 0);
    clr_log(); wcmd(3, 0, 0, 0, 0, 1); wait_done();
    chk(nreq == 0 && err == 1, "R8", "op3 rejected", nreq, 0);
    prog_en = 2'b11;

    // R3: writes while locked are ignored
    clr_log(); ack_lat = 3; waddr('h100); wcmd(0, 0, 0, 0, 3, 1);
    waddr('h400); wcmd(2, 1, 0, 0, 0, 1); wait_done();
    repeat (6) @(negedge clk);
    chk(nreq == 4 && regwen == 1 && !fl_req, "R3", "no restart", nreq, 4);
    clr_log(); ack_lat = 0; wcmd(0, 0, 0, 0, 0, 1); wait_done();
    chk(nreq == 1 && addrs[0] == 'h100, "R3", "old addr kept", addrs[0], 'h100);

    // R9: suspend while idle is dropped
    pulse_susp(); @(negedge clk);
    chk(fl_susp_req == 0, "R9", "idle suspend", fl_susp_req, 0);

    // R10: suspend during erase held until acknowledged
    clr_log(); ack_lat = 12; waddr('h3000); wcmd(2, 0, 0, 0, 0, 1);
    pulse_susp(); @(negedge clk);
    chk(fl_susp_req == 1, "R10", "suspend forwarded", fl_susp_req, 1);
    @(posedge clk); #2; fl_susp_ack = 1;
    @(posedge clk); #2; fl_susp_ack = 0;
    @(negedge clk);
    chk(fl_susp_req == 0, "R10", "suspend cleared", fl_susp_req, 0);
    wait_done();
    chk(nreq == 1, "R10", "erase completes", nreq, 1);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule